// File: doc/BRIEF.md
# CAN Bit Timing Generator

This block cuts every CAN bit period into three consecutive parts counted in system clocks: a synchronization slot that is always one clock long, a first timing segment of 1 to 16 clocks, and a second timing segment of 1 to 8 clocks. The first segment is one programmable count. It absorbs both the propagation-delay allowance and the phase buffer in front of the sample point, with no separate counter for either. The receive line is captured at the end of the first segment. The transmit point, where a bit engine drives its next output bit, falls on the synchronization slot. A bit engine or protocol layer uses the two strobes to pace its transmit and receive shift logic.

The raw receive line passes through a two-stage synchronizer. While the bus is reported idle, the first falling (recessive-to-dominant) edge triggers a hard synchronization. The cycle in which that edge is seen becomes the synchronization slot of a new bit. The strobes and the sampled bit are plain, unhandshaked outputs: there is no back-pressure, and a consumer must act on each one-clock strobe in the cycle it appears. Segment lengths come from configuration inputs. They are latched only during reset, or at the end of a bit while the bus is idle.

Top module: `can_bit_timer`

## Requirements
- R1: During and right after a synchronous reset (rst_n low), the timer sits in the synchronization slot. In the first cycle after release, tx_point=1, sample_point=0 and rx_bit=1.
- R2: tx_point is one clock wide and marks the synchronization slot. Without a hard synchronization, consecutive tx_point pulses are exactly 3+seg1_len+seg2_len clocks apart. The timer keeps running and stays periodic while idle and unsynchronized.
- R3: seg1_len holds the first segment length minus one (0..15 gives 1..16 clocks). sample_point is high seg1_len+1 clocks after the tx_point cycle.
- R4: At the end of a sample_point cycle, rx_bit takes the value rx_in had two clock edges earlier. In every other cycle rx_bit holds its value.
- R5: seg2_len holds the second segment length minus one (0..7 gives 1..8 clocks). It sets the gap from the sample_point cycle to the next tx_point, which is seg2_len+2 clocks.
- R6: Segment lengths are latched during reset, and at a bit's last clock only when bus_idle=1. A change while bus_idle=0 leaves the bit period unchanged.
- R7: A hard synchronization occurs when bus_idle=1, the timer is armed, and the synchronized receive line goes from 1 (recessive) to 0 (dominant). That cycle is then the synchronization slot, so the next sample_point follows seg1_len+1 clocks later. tx_point is raised in that cycle unless the previous cycle was already a synchronization slot.
- R8: After a hard synchronization the timer is disarmed. Further falling edges are ignored until bus_idle has been 0 for at least one clock, which re-arms it.
- R9: While bus_idle=0, receive edges have no effect on bit timing.
- R10: sample_point is one clock wide and is never high in the same cycle as tx_point. The shortest bit is 3 clocks.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; all segments are counted in its cycles |
| rst_n | input | 1 | Synchronous active-low reset; also latches segment lengths |
| rx_in | input | 1 | Raw receive line, 0 = dominant, 1 = recessive |
| bus_idle | input | 1 | High while the bus is idle; enables hard sync and length reload |
| seg1_len | input | 4 | First segment length minus one |
| seg2_len | input | 3 | Second segment length minus one |
| tx_point | output | 1 | One-clock strobe at the synchronization slot |
| sample_point | output | 1 | One-clock strobe at the last clock of the first segment |
| rx_bit | output | 1 | Receive value captured at the last sample point |

## Verification
The assertions assume that rst_n, bus_idle and both length fields change only between clock edges. They also assume that reset is held for at least one edge, so the synchronizer and the phase state start from known values. The stimulus drives every input on the falling clock edge. It keeps the length fields inside their widths and holds reset for several cycles. Edges on rx_in are placed both inside and outside idle periods, so the arming rule is covered from both sides.

// File: rtl/can_bt_pkg.sv
package can_bt_pkg;
  typedef enum logic [1:0] {
    PH_SYNC = 2'd0,
    PH_SEG1 = 2'd1,
    PH_SEG2 = 2'd2
  } bt_phase_e;
endpackage

// File: rtl/can_bt_rxsync.sv
module can_bt_rxsync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic rx_raw,
  output logic rx_s,
  output logic fall
);
  logic [STAGES-1:0] sr;
  logic              prev;

  // shift chain, recessive on reset
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sr   <= '1;
      prev <= 1'b1;
    end else begin
      sr   <= {sr[STAGES-2:0], rx_raw};
      prev <= sr[STAGES-1];
    end
  end

  assign rx_s = sr[STAGES-1];
  assign fall = prev & ~rx_s;
endmodule

// File: rtl/can_bt_hardsync.sv
module can_bt_hardsync (
  input  logic clk,
  input  logic rst_n,
  input  logic bus_idle,
  input  logic fall,
  output logic fire,
  output logic armed
);
  assign fire = fall & bus_idle & armed;

  // disarm on firing, re-arm once the bus leaves idle
  always_ff @(posedge clk) begin
    if (!rst_n)         armed <= 1'b1;
    else if (fire)      armed <= 1'b0;
    else if (!bus_idle) armed <= 1'b1;
  end
endmodule

// File: rtl/can_bt_segcnt.sv
module can_bt_segcnt
  import can_bt_pkg::*;
#(
  parameter int T1_W = 4,
  parameter int T2_W = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            bus_idle,
  input  logic [T1_W-1:0] seg1_len,
  input  logic [T2_W-1:0] seg2_len,
  input  logic            fire,
  output bt_phase_e       phase,
  output logic            tx_point,
  output logic            sample_point
);
  localparam int CNT_W = (T1_W > T2_W) ? T1_W : T2_W;

  logic [CNT_W-1:0] cnt;
  logic [T1_W-1:0]  t1_q;
  logic [T2_W-1:0]  t2_q;
  logic             last1, last2, seg1_first;

  assign last1      = (phase == PH_SEG1) && (cnt == CNT_W'(t1_q));
  assign last2      = (phase == PH_SEG2) && (cnt == CNT_W'(t2_q));
  assign seg1_first = (phase == PH_SEG1) && (cnt == '0);

  // active lengths: loaded in reset or at a bit boundary while idle
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      t1_q <= seg1_len;
      t2_q <= seg2_len;
    end else if (last2 && bus_idle && !fire) begin
      t1_q <= seg1_len;
      t2_q <= seg2_len;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase <= PH_SYNC;
      cnt   <= '0;
    end else if (fire) begin
      phase <= PH_SEG1;
      cnt   <= '0;
    end else begin
      unique case (phase)
        PH_SYNC: begin
          phase <= PH_SEG1;
          cnt   <= '0;
        end
        PH_SEG1: begin
          if (last1) begin
            phase <= PH_SEG2;
            cnt   <= '0;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        PH_SEG2: begin
          if (last2) begin
            phase <= PH_SYNC;
            cnt   <= '0;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        default: begin
          phase <= PH_SYNC;
          cnt   <= '0;
        end
      endcase
    end
  end

  assign tx_point     = (phase == PH_SYNC) | (fire & ~seg1_first);
  assign sample_point = last1 & ~fire;
endmodule

// File: rtl/can_bit_timer.sv
module can_bit_timer
  import can_bt_pkg::*;
#(
  parameter int T1_W        = 4,
  parameter int T2_W        = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            rx_in,
  input  logic            bus_idle,
  input  logic [T1_W-1:0] seg1_len,
  input  logic [T2_W-1:0] seg2_len,
  output logic            tx_point,
  output logic            sample_point,
  output logic            rx_bit
);
  logic      rx_s, fall, fire, armed;
  bt_phase_e phase;

  can_bt_rxsync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .rx_raw(rx_in), .rx_s(rx_s), .fall(fall)
  );

  can_bt_hardsync u_hs (
    .clk(clk), .rst_n(rst_n), .bus_idle(bus_idle), .fall(fall),
    .fire(fire), .armed(armed)
  );

  can_bt_segcnt #(.T1_W(T1_W), .T2_W(T2_W)) u_seg (
    .clk(clk), .rst_n(rst_n), .bus_idle(bus_idle),
    .seg1_len(seg1_len), .seg2_len(seg2_len), .fire(fire),
    .phase(phase), .tx_point(tx_point), .sample_point(sample_point)
  );

  // bit capture at the sample point
  always_ff @(posedge clk) begin
    if (!rst_n)            rx_bit <= 1'b1;
    else if (sample_point) rx_bit <= rx_s;
  end
endmodule

// File: rtl/can_bit_timer_chk.sv
module can_bit_timer_chk
  import can_bt_pkg::*;
(
  input logic      clk,
  input logic      rst_n,
  input logic      tx_point,
  input logic      sample_point,
  input logic      rx_bit,
  input logic      rx_s,
  input logic      fire,
  input logic      armed,
  input bt_phase_e phase
);
  // R10
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(tx_point && sample_point));

  // R2
  tx_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_point |=> !tx_point);

  // R10
  smp_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sample_point |=> !sample_point);

  // R4
  bit_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sample_point |=> (rx_bit == $past(rx_s)));

  // R4
  bit_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !sample_point |=> $stable(rx_bit));

  // R7
  hs_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> (phase == PH_SEG1) && !tx_point);

  // R8
  hs_disarm_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> !armed);
endmodule

bind can_bit_timer can_bit_timer_chk u_chk (
  .clk(clk), .rst_n(rst_n), .tx_point(tx_point), .sample_point(sample_point),
  .rx_bit(rx_bit), .rx_s(rx_s), .fire(fire), .armed(armed), .phase(phase)
);

// File: tb/sim_can_bit_timer.sv
`timescale 1ns/1ps
module sim_can_bit_timer;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0, rx_in = 1'b1, bus_idle = 1'b1;
  logic [3:0] seg1_len = 4'd3;
  logic [2:0] seg2_len = 3'd2;
  logic       tx_point, sample_point, rx_bit;

  int checks = 0, errors = 0;
  bit cmp_en = 0;

  // next-cycle stimulus
  logic       nx_rst = 1'b0, nx_rx = 1'b1, nx_idle = 1'b1;
  logic [3:0] nx_c1 = 4'd3;
  logic [2:0] nx_c2 = 3'd2;

  // reference model state
  bit m_s1 = 1, m_s2 = 1, m_d = 1, m_arm = 1, m_bit = 1;
  int m_pos = 0, m_t1 = 4, m_t2 = 3;

  always #5 clk = ~clk;

  can_bit_timer u0 (
    .clk(clk), .rst_n(rst_n), .rx_in(rx_in), .bus_idle(bus_idle),
    .seg1_len(seg1_len), .seg2_len(seg2_len),
    .tx_point(tx_point), .sample_point(sample_point), .rx_bit(rx_bit)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s act=%0d exp=%0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic bit m_fire(input bit idle);
    return m_d && !m_s2 && idle && m_arm;
  endfunction

  task automatic step();
    bit f;
    @(negedge clk);
    if (cmp_en && rst_n) begin
      f = m_fire(bus_idle);
      check("R2/R7 tx_point", int'(tx_point), int'((m_pos == 0) || (f && m_pos != 1)));
      check("R3/R10 sample_point", int'(sample_point), int'((m_pos == m_t1) && !f));
      check("R4 rx_bit", int'(rx_bit), int'(m_bit));
    end
    rst_n = nx_rst; rx_in = nx_rx; bus_idle = nx_idle;
    seg1_len = nx_c1; seg2_len = nx_c2;
    if (!nx_rst) begin
      m_s1 = 1; m_s2 = 1; m_d = 1; m_arm = 1; m_bit = 1; m_pos = 0;
      m_t1 = int'(nx_c1) + 1; m_t2 = int'(nx_c2) + 1;
    end else begin
      f = m_fire(nx_idle);
      if (m_pos == m_t1 && !f) m_bit = m_s2;
      if (f) m_pos = 1;
      else if (m_pos == m_t1 + m_t2) begin
        m_pos = 0;
        if (nx_idle) begin m_t1 = int'(nx_c1) + 1; m_t2 = int'(nx_c2) + 1; end
      end else m_pos++;
      if (f) m_arm = 0; else if (!nx_idle) m_arm = 1;
      m_d = m_s2; m_s2 = m_s1; m_s1 = nx_rx;
    end
  endtask

  task automatic run(input int n);
    for (int i = 0; i < n; i++) step();
  endtask

  task automatic meas(input string req, input int exp);
    int n;
    while (!tx_point) step();
    step(); n = 1;
    while (!tx_point) begin step(); n++; end
    check(req, n, exp);
  endtask

  task automatic gap_to_sample(input string req, input int exp);
    int n = 0;
    while (!sample_point) begin step(); n++; end
    check(req, n, exp);
  endtask

  initial begin
    #1500000;
    errors++;
    $display("FAIL watchdog act=0 exp=1");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_0042));
    nx_rst = 0; run(4);
    nx_rst = 1; step();
    // R1: reset state in first cycle after release
    check("R1 tx_point", int'(tx_point), 1);
    check("R1 sample_point", int'(sample_point), 0);
    check("R1 rx_bit", int'(rx_bit), 1);
    cmp_en = 1;
    run(20);
    // R2 free-running period 1+4+3
    meas("R2 period", 8);
    while (!tx_point) step();
    gap_to_sample("R3 tx to sample", 4);
    step();
    meas("R5 period", 8);
    // R6: change while busy is ignored
    nx_idle = 0; nx_c1 = 4'd15; nx_c2 = 3'd7; run(3);
    meas("R6 busy period", 8);
    meas("R6 busy period again", 8);
    nx_idle = 1; run(10);
    meas("R6 idle reload", 25);
    nx_c1 = 4'd0; nx_c2 = 3'd0; run(30);
    meas("R10 minimum bit", 3);
    nx_c1 = 4'd15; nx_c2 = 3'd7; run(30);
    // R7 hard sync mid-bit
    while (!tx_point) step();
    run(5);
    nx_rx = 0; step(); step(); step();
    check("R7 restart strobe", int'(tx_point), 1);
    gap_to_sample("R7 sync to sample", 16);
    // R8 second edge in same idle ignored
    nx_rx = 1; run(4);
    while (!tx_point) step();
    run(5); nx_rx = 0; step();
    meas("R8 no refire", 25);
    // R9 edges while busy ignored
    nx_idle = 0; nx_rx = 1; run(3);
    while (!tx_point) step();
    run(4); nx_rx = 0; step();
    meas("R9 busy edge", 25);
    // R8 re-arm after leaving idle
    nx_rx = 1; run(4); nx_idle = 1; run(2);
    while (!tx_point) step();
    run(7); nx_rx = 0; step(); step(); step();
    check("R8 rearmed fire", int'(tx_point), 1);
    // random mix
    for (int i = 0; i < 6000; i++) begin
      if ($urandom_range(0, 5) == 0)  nx_rx = ~nx_rx;
      if ($urandom_range(0, 59) == 0) nx_idle = ~nx_idle;
      if ($urandom_range(0, 49) == 0) begin
        nx_c1 = 4'($urandom_range(0, 15));
        nx_c2 = 3'($urandom_range(0, 7));
      end
      step();
    end
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule